// File: doc/BRIEF.md
# Cut-Through Flit Forwarding Switch

This block is one router node of a multi-hop network in which every message moves as a train of small flits. The first flit of a message travels as a tracer. Its payload names the output port the message must leave by. When that tracer is accepted, the switch ties the chosen output to the input that sent it. Each later flit from that input then uses the same output, in arrival order, with no routing field and no sequence number of its own. The tie is undone once the closing flit has gone through. A flit is forwarded as soon as it arrives, with one register stage per output, so the router never holds a whole message.

Every input and every output is a valid/ready stream. A flit moves across a port only in a cycle where both valid and ready are high. An output register holds its flit unchanged while the downstream side keeps ready low, and a full output register pulls ready low on the input that feeds it. A tracer that asks for an output already tied to another input waits with ready low. Tracers that want the same free output in the same cycle are served in round-robin order. Integrity is checked once per message: the closing flit carries an XOR of the message's earlier payloads, and the switch raises a one-cycle error strobe on that input when the value does not match.

Top module: `ct_flit_switch`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) every `out_valid` bit is low, every `sum_err` bit is low and no output is tied to any input.
- R2: A flit is `PAY_W+2` bits wide. Bits [PAY_W+1:PAY_W] give its kind: 00 tracer, 01 body, 10 closing, 11 one-flit message. Bits [PAY_W-1:0] are the payload. In a tracer or one-flit message, payload bits [log2(NUM_OUT)-1:0] select the output port.
- R3: A flit moves only when valid and ready are both high. An accepted flit appears unchanged on its output in the cycle after the accepting edge. While `out_valid` is high and `out_ready` is low, the output flit is held stable, and an input whose flit needs that output sees ready low.
- R4: After an input's tracer is accepted, every later flit from that input, whatever its kind or payload, goes to the output the tracer chose, in the order it was sent.
- R5: The tie between an input and an output ends with the transfer of the closing flit. A one-flit message passes through without tying its output.
- R6: A tracer or one-flit message that asks for an output tied to another input is held with ready low until that tie ends.
- R7: When several inputs present a tracer for the same free output in the same cycle, the output serves them in round-robin order. Priority starts at input 0 and, after each grant, moves to the input after the one granted.
- R8: At a closing flit, the switch compares the payload with the XOR of the payloads of the tracer and all body flits of that message. On a mismatch, `sum_err` for that input is high for exactly the one cycle after the closing flit's accepting edge. The closing flit is forwarded in either case.
- R9: A body or closing flit that arrives at an input with no open path is accepted (ready high) and dropped, so no output becomes valid because of it.
- R10: Messages from different inputs to different outputs move in the same cycles, each at one flit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_IN | Per-input flit valid |
| in_ready | output | NUM_IN | Per-input ready; transfer when valid and ready are both high |
| in_flit | input | NUM_IN*(PAY_W+2) | Input flits, input i at bits [i*(PAY_W+2) +: PAY_W+2] |
| out_valid | output | NUM_OUT | Per-output flit valid |
| out_ready | input | NUM_OUT | Per-output downstream ready |
| out_flit | output | NUM_OUT*(PAY_W+2) | Output flits, output o at bits [o*(PAY_W+2) +: PAY_W+2] |
| sum_err | output | NUM_IN | One-cycle strobe per input when a message check word mismatches |

## Verification
A flit accepted at one clock edge is due on its output after that edge. The bench drives one nanosecond after each rising edge, reads ready two nanoseconds after it, and compares the output one cycle after the handshake it recorded. The error strobe is due in the cycle after the closing flit's handshake. It is checked every cycle against an expectation set at the handshake, so a missing, late or stretched pulse is caught. Flits that wait under back-pressure are compared against the value seen in the previous cycle. Random traffic is scored per input and output pair, so that order is judged only where the switch guarantees it.

// File: rtl/ct_flit_pkg.sv
package ct_flit_pkg;
  typedef enum logic [1:0] {
    FK_HEAD = 2'b00,
    FK_BODY = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/ct_rr_pick.sv
module ct_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned c;
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/ct_port_track.sv
module ct_port_track
  import ct_flit_pkg::*;
#(
  parameter int PAY_W = 8,
  parameter int DST_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  flit_kind_e       kind,
  input  logic [PAY_W-1:0] payload,
  output logic             busy,
  output logic [DST_W-1:0] route,
  output logic             sum_err
);
  logic [PAY_W-1:0] run_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      route   <= '0;
      run_sum <= '0;
      sum_err <= 1'b0;
    end else begin
      sum_err <= 1'b0;
      if (xfer) begin
        if (!busy) begin
          if (kind == FK_HEAD) begin
            busy    <= 1'b1;
            route   <= payload[DST_W-1:0];
            run_sum <= payload;
          end
        end else if (kind == FK_TAIL) begin
          busy    <= 1'b0;
          sum_err <= (run_sum != payload);
        end else begin
          run_sum <= run_sum ^ payload;
        end
      end
    end
  end
endmodule

// File: rtl/ct_out_lane.sv
module ct_out_lane
  import ct_flit_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int FLIT_W = 10,
  parameter int SRC_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        in_valid,
  input  logic [NUM_IN*FLIT_W-1:0] in_flit,
  input  logic [NUM_IN-1:0]        hdr_req,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [FLIT_W-1:0]        out_flit,
  output logic [NUM_IN-1:0]        accept_from
);
  logic              locked;
  logic [SRC_W-1:0]  owner;
  logic              gnt_any;
  logic [SRC_W-1:0]  gnt_idx;
  logic [SRC_W-1:0]  sel_idx;
  logic              sel_live;
  logic              room;
  logic              take;
  logic [FLIT_W-1:0] sel_flit;
  flit_kind_e        sel_kind;
  logic [NUM_IN-1:0] arb_req;
  logic              arb_adv;

  assign arb_req = hdr_req & {NUM_IN{~locked}};
  assign arb_adv = take & ~locked;

  ct_rr_pick #(.N(NUM_IN), .IW(SRC_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (arb_req),
    .adv     (arb_adv),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  always_comb begin
    room     = !out_valid || out_ready;
    sel_idx  = locked ? owner : gnt_idx;
    sel_live = locked ? in_valid[sel_idx] : gnt_any;
    take     = sel_live && room;
    sel_flit = in_flit[sel_idx*FLIT_W +: FLIT_W];
    sel_kind = flit_kind_e'(sel_flit[FLIT_W-1 -: 2]);
    accept_from = '0;
    if ((locked || gnt_any) && room) accept_from[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      owner     <= '0;
      out_valid <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= take | (out_valid & ~out_ready);
      if (take) out_flit <= sel_flit;
      if (!locked && take && sel_kind == FK_HEAD) begin
        locked <= 1'b1;
        owner  <= gnt_idx;
      end else if (locked && take && sel_kind == FK_TAIL) begin
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ct_flit_switch.sv
module ct_flit_switch
  import ct_flit_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int PAY_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_IN-1:0]                 in_valid,
  output logic [NUM_IN-1:0]                 in_ready,
  input  logic [NUM_IN*(PAY_W+2)-1:0]       in_flit,
  output logic [NUM_OUT-1:0]                out_valid,
  input  logic [NUM_OUT-1:0]                out_ready,
  output logic [NUM_OUT*(PAY_W+2)-1:0]      out_flit,
  output logic [NUM_IN-1:0]                 sum_err
);
  localparam int FLIT_W = PAY_W + 2;
  localparam int DST_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int SRC_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  flit_kind_e        kind     [NUM_IN];
  logic [PAY_W-1:0]  payload  [NUM_IN];
  logic [DST_W-1:0]  dst      [NUM_IN];
  logic [DST_W-1:0]  route    [NUM_IN];
  logic [NUM_IN-1:0] busy;
  logic [NUM_IN-1:0] path_kind;
  logic [NUM_IN-1:0] wants_path;
  logic [NUM_IN-1:0] xfer;
  logic [NUM_IN-1:0] acc_from [NUM_OUT];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign kind[i]       = flit_kind_e'(in_flit[i*FLIT_W+PAY_W +: 2]);
    assign payload[i]    = in_flit[i*FLIT_W +: PAY_W];
    assign dst[i]        = payload[i][DST_W-1:0];
    assign path_kind[i]  = (kind[i] == FK_HEAD) || (kind[i] == FK_SOLO);
    assign wants_path[i] = in_valid[i] && !busy[i] && path_kind[i];
    assign xfer[i]       = in_valid[i] && in_ready[i];

    ct_port_track #(.PAY_W(PAY_W), .DST_W(DST_W)) u_track (
      .clk     (clk),
      .rst     (rst),
      .xfer    (xfer[i]),
      .kind    (kind[i]),
      .payload (payload[i]),
      .busy    (busy[i]),
      .route   (route[i]),
      .sum_err (sum_err[i])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_IN-1:0] req_here;

    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        req_here[i] = wants_path[i] && (dst[i] == DST_W'(o));
      end
    end

    ct_out_lane #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W), .SRC_W(SRC_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_flit     (in_flit),
      .hdr_req     (req_here),
      .out_ready   (out_ready[o]),
      .out_valid   (out_valid[o]),
      .out_flit    (out_flit[o*FLIT_W +: FLIT_W]),
      .accept_from (acc_from[o])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      if (busy[i])           in_ready[i] = acc_from[route[i]][i];
      else if (path_kind[i]) in_ready[i] = acc_from[dst[i]][i];
      else                   in_ready[i] = 1'b1;
    end
  end
endmodule

// File: rtl/ct_flit_switch_chk.sv
module ct_flit_switch_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int PAY_W   = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_IN-1:0]            in_valid,
  input logic [NUM_IN-1:0]            in_ready,
  input logic [NUM_IN*(PAY_W+2)-1:0]  in_flit,
  input logic [NUM_OUT-1:0]           out_valid,
  input logic [NUM_OUT-1:0]           out_ready,
  input logic [NUM_OUT*(PAY_W+2)-1:0] out_flit,
  input logic [NUM_IN-1:0]            sum_err
);
  localparam int FW = PAY_W + 2;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && sum_err == '0));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
    a_r3_hold_stalled: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o*FW +: FW])));
    a_r3_needs_handshake: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid[o]) |-> $past(|(in_valid & in_ready)));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_i
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      sum_err[i] |=> !sum_err[i]);
    a_r8_after_tail: assert property (@(posedge clk) disable iff (rst)
      sum_err[i] |-> $past(in_valid[i] && in_ready[i] && in_flit[i*FW+PAY_W +: 2] == 2'b10));
  end
endmodule

bind ct_flit_switch ct_flit_switch_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .PAY_W(PAY_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
  .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .sum_err(sum_err)
);

// File: tb/sim_ct_flit_switch.sv
module sim_ct_flit_switch;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int PW = 8;
  localparam int FW = PW + 2;
  localparam logic [1:0] K_HEAD = 2'b00, K_BODY = 2'b01, K_TAIL = 2'b10, K_SOLO = 2'b11;

  logic clk = 1'b0;
  logic rst;
  logic [NI-1:0]    in_valid, in_ready, sum_err;
  logic [NI*FW-1:0] in_flit;
  logic [NO-1:0]    out_valid, out_ready;
  logic [NO*FW-1:0] out_flit;

  always #2 clk = ~clk;

  ct_flit_switch #(.NUM_IN(NI), .NUM_OUT(NO), .PAY_W(PW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .sum_err(sum_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [PW-1:0] p);
    return {k, p};
  endfunction

  function automatic logic [PW-1:0] hdr_pay(input int src, input int dst, input logic [3:0] r);
    return {r, 2'(src), 2'(dst)};
  endfunction

  task automatic drv(input int i, input logic v, input logic [FW-1:0] f);
    in_valid[i] = v;
    in_flit[i*FW +: FW] = f;
  endtask

  function automatic logic [FW-1:0] oflit(input int o);
    return out_flit[o*FW +: FW];
  endfunction

  task automatic chk_out(input int o, input logic [FW-1:0] e, input string req);
    chk(out_valid[o] && oflit(o) == e, req, {out_valid[o], oflit(o)}, {1'b1, e});
  endtask

  task automatic adv();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  // random traffic state
  logic [FW-1:0] msg [NI][6];
  int  mlen [NI];
  int  mpos [NI];
  int  mdst [NI];
  bit  mact [NI];
  bit  mbad [NI];
  logic [FW-1:0] sbq [NI*NO][$];
  int  cur [NO];
  bit  exp_err [NI];
  bit  stall [NO];
  logic [FW-1:0] held [NO];

  task automatic gen_msg(input int i);
    int d, n;
    logic [PW-1:0] x, p;
    d = int'($urandom % NO);
    n = 1 + int'($urandom % 5);
    mdst[i] = d;
    mlen[i] = n;
    mpos[i] = 0;
    mact[i] = 1'b1;
    mbad[i] = 1'b0;
    p = hdr_pay(i, d, 4'($urandom));
    if (n == 1) begin
      msg[i][0] = mk(K_SOLO, p);
    end else begin
      msg[i][0] = mk(K_HEAD, p);
      x = p;
      for (int b = 1; b < n - 1; b++) begin
        p = PW'($urandom);
        msg[i][b] = mk(K_BODY, p);
        x = x ^ p;
      end
      if ($urandom % 6 == 0) begin
        mbad[i] = 1'b1;
        x = x ^ 8'h5A;
      end
      msg[i][n-1] = mk(K_TAIL, x);
    end
  endtask

  task automatic pop_out(input int o);
    logic [FW-1:0] f, e;
    int s;
    f = oflit(o);
    if (f[FW-1 -: 2] == K_HEAD || f[FW-1 -: 2] == K_SOLO) begin
      s = int'(f[3:2]);
      chk(int'(f[1:0]) == o, "R2 dest field selects output", f[1:0], o);
      if (f[FW-1 -: 2] == K_HEAD) cur[o] = s;
    end else begin
      s = cur[o];
    end
    if (s < 0 || sbq[s*NO+o].size() == 0) begin
      chk(1'b0, "R4 unexpected flit on output", f, 0);
    end else begin
      e = sbq[s*NO+o].pop_front();
      chk(f == e, "R4 flit order on reserved path", f, e);
    end
  endtask

  task automatic rand_cycle(input bit gen_on);
    adv();
    for (int o = 0; o < NO; o++)
      if (stall[o]) chk(out_valid[o] && oflit(o) == held[o], "R3 stalled output held", oflit(o), held[o]);
    for (int i = 0; i < NI; i++)
      chk(sum_err[i] == exp_err[i], "R8 check word strobe", sum_err[i], exp_err[i]);
    for (int i = 0; i < NI; i++) begin
      if (!mact[i] && gen_on && ($urandom % 3 == 0)) gen_msg(i);
      drv(i, mact[i], mact[i] ? msg[i][mpos[i]] : '0);
    end
    for (int o = 0; o < NO; o++) out_ready[o] = gen_on ? (($urandom % 4) != 0) : 1'b1;
    settle();
    for (int o = 0; o < NO; o++) begin
      if (out_valid[o] && out_ready[o]) pop_out(o);
      stall[o] = out_valid[o] && !out_ready[o];
      held[o]  = oflit(o);
    end
    for (int i = 0; i < NI; i++) begin
      exp_err[i] = 1'b0;
      if (in_valid[i] && in_ready[i]) begin
        sbq[i*NO+mdst[i]].push_back(msg[i][mpos[i]]);
        if (msg[i][mpos[i]][FW-1 -: 2] == K_TAIL) exp_err[i] = mbad[i];
        mpos[i]++;
        if (mpos[i] == mlen[i]) mact[i] = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    in_valid = '0;
    in_flit = '0;
    out_ready = '1;
    for (int i = 0; i < NI; i++) begin mact[i] = 0; exp_err[i] = 0; mpos[i] = 0; end
    for (int o = 0; o < NO; o++) begin cur[o] = -1; stall[o] = 0; held[o] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    adv();
    chk(out_valid == '0, "R1 no output valid after reset", out_valid, 0);
    chk(sum_err == '0, "R1 no error after reset", sum_err, 0);
    // tracer in0 -> out1
    drv(0, 1, mk(K_HEAD, 8'h01));
    settle();
    chk(in_ready[0], "R1 free path after reset", in_ready[0], 1);
    adv();
    chk_out(1, mk(K_HEAD, 8'h01), "R3 one-cycle forward of tracer");
    chk(out_valid[0] == 0 && out_valid[2] == 0 && out_valid[3] == 0, "R4 only chosen output", out_valid, 4'b0010);
    drv(0, 1, mk(K_BODY, 8'h3C));
    drv(1, 1, mk(K_HEAD, 8'h05));
    settle();
    chk(in_ready[0] == 1 && in_ready[1] == 0, "R6 tracer blocked by tied output", in_ready, 4'b0001);
    adv();
    chk_out(1, mk(K_BODY, 8'h3C), "R4 body follows tracer path");
    drv(0, 1, mk(K_TAIL, 8'h3D));
    settle();
    chk(in_ready[1] == 0, "R6 still blocked before tail", in_ready[1], 0);
    adv();
    chk_out(1, mk(K_TAIL, 8'h3D), "R4 tail follows tracer path");
    drv(0, 0, '0);
    settle();
    chk(in_ready[1] == 1, "R5 path released after tail", in_ready[1], 1);
    adv();
    chk(sum_err[0] == 0, "R8 matching check word no strobe", sum_err[0], 0);
    chk_out(1, mk(K_HEAD, 8'h05), "R5 waiting tracer forwarded");
    drv(1, 1, mk(K_TAIL, 8'h05));
    adv();
    chk_out(1, mk(K_TAIL, 8'h05), "R4 tail of second message");
    drv(1, 0, '0);
    adv();
    chk(sum_err == '0, "R8 good message no strobe", sum_err, 0);
    // one-flit message does not tie its output
    drv(2, 1, mk(K_SOLO, 8'h0B));
    adv();
    chk_out(3, mk(K_SOLO, 8'h0B), "R3 one-flit message forwarded");
    drv(2, 0, '0);
    drv(3, 1, mk(K_HEAD, 8'h0F));
    settle();
    chk(in_ready[3] == 1, "R5 one-flit message leaves output free", in_ready[3], 1);
    adv();
    chk_out(3, mk(K_HEAD, 8'h0F), "R3 tracer after one-flit message");
    drv(3, 1, mk(K_TAIL, 8'h00));
    adv();
    chk_out(3, mk(K_TAIL, 8'h00), "R8 bad tail still forwarded");
    chk(sum_err == 4'b1000, "R8 mismatch strobe on input 3", sum_err, 4'b1000);
    drv(3, 0, '0);
    // contention for out0
    drv(0, 1, mk(K_HEAD, 8'h00));
    drv(1, 1, mk(K_HEAD, 8'h04));
    settle();
    adv();
    chk(sum_err == '0, "R8 strobe lasts one cycle", sum_err, 0);
    chk_out(0, mk(K_HEAD, 8'h00), "R7 input 0 wins first contention");
    drv(0, 1, mk(K_TAIL, 8'h00));
    settle();
    chk(in_ready[1] == 0, "R7 loser waits", in_ready[1], 0);
    adv();
    drv(0, 1, mk(K_HEAD, 8'h00));
    settle();
    chk(in_ready[1] == 1 && in_ready[0] == 0, "R7 priority rotates to input 1", in_ready[1:0], 2'b10);
    adv();
    chk_out(0, mk(K_HEAD, 8'h04), "R7 input 1 tracer forwarded");
    drv(1, 1, mk(K_TAIL, 8'h04));
    adv();
    drv(1, 0, '0);
    settle();
    chk(in_ready[0] == 1, "R7 input 0 served after release", in_ready[0], 1);
    adv();
    chk_out(0, mk(K_HEAD, 8'h00), "R7 input 0 tracer forwarded");
    drv(0, 1, mk(K_TAIL, 8'h00));
    adv();
    drv(0, 0, '0);
    adv();
    // stray body on idle input
    drv(2, 1, mk(K_BODY, 8'h77));
    settle();
    chk(in_ready[2] == 1, "R9 stray body accepted", in_ready[2], 1);
    adv();
    drv(2, 0, '0);
    chk(out_valid == '0, "R9 stray body dropped", out_valid, 0);
    // back-pressure
    out_ready[2] = 1'b0;
    drv(0, 1, mk(K_HEAD, 8'h02));
    adv();
    chk_out(2, mk(K_HEAD, 8'h02), "R3 tracer in output register");
    drv(0, 1, mk(K_BODY, 8'h11));
    settle();
    chk(in_ready[0] == 0, "R3 full output blocks input", in_ready[0], 0);
    adv();
    chk_out(2, mk(K_HEAD, 8'h02), "R3 output held under back-pressure");
    out_ready[2] = 1'b1;
    settle();
    chk(in_ready[0] == 1, "R3 ready returns with downstream", in_ready[0], 1);
    adv();
    chk_out(2, mk(K_BODY, 8'h11), "R3 body after stall");
    drv(0, 1, mk(K_TAIL, 8'h13));
    adv();
    drv(0, 0, '0);
    adv();
    chk(sum_err[0] == 0, "R8 good check word after stall", sum_err[0], 0);
    // parallel paths
    drv(0, 1, mk(K_HEAD, 8'h02));
    drv(1, 1, mk(K_HEAD, 8'h07));
    settle();
    chk(in_ready[1:0] == 2'b11, "R10 both inputs accepted together", in_ready[1:0], 2'b11);
    adv();
    chk_out(2, mk(K_HEAD, 8'h02), "R10 path to output 2");
    chk_out(3, mk(K_HEAD, 8'h07), "R10 path to output 3");
    drv(0, 1, mk(K_TAIL, 8'h02));
    drv(1, 1, mk(K_TAIL, 8'h07));
    adv();
    chk_out(2, mk(K_TAIL, 8'h02), "R10 tail on output 2");
    chk_out(3, mk(K_TAIL, 8'h07), "R10 tail on output 3");
    drv(0, 0, '0);
    drv(1, 0, '0);
    adv();
    adv();

    // random traffic
    for (int c = 0; c < 4000; c++) rand_cycle(1'b1);
    for (int c = 0; c < 300; c++) rand_cycle(1'b0);
    for (int q = 0; q < NI*NO; q++)
      chk(sbq[q].size() == 0, "R4 every accepted flit delivered", sbq[q].size(), 0);
    for (int i = 0; i < NI; i++)
      chk(!mact[i], "R6 no message left stalled", mact[i], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule